// File: doc/BRIEF.md
# Multicycle Load/Store Datapath

This block is the datapath of a small 32-bit processor in which each instruction passes through several short steps and reuses the same hardware in every step. One ALU serves three purposes: it advances the program counter, it computes memory addresses and branch targets, and it performs the arithmetic. One memory port serves both instruction fetch and data access. Between steps the block keeps its values in internal registers: instruction, memory data, the two operand latches and the ALU result latch. It also holds the program counter and a 32-entry register file.

The block makes no decisions of its own. An external sequencer drives every register enable, every multiplexer select and the ALU operation in every cycle. The block returns the opcode and function fields of the held instruction and a zero flag from the ALU result, and the sequencer uses these to choose its next step. Loads take five steps, stores and register-register operations take four, and branches and jumps take three.

Top module: `mc_datapath`

## Requirements
- R1: When `ir_wr` is high, the instruction register captures `mem_rdata` at the clock edge. In the same edge, with `pc_wr`=1, `pc_sel`=00, `src_a_sel`=0, `src_b_sel`=01 and `alu_op`=010, the program counter becomes its old value plus 4.
- R2: The instruction register keeps its value in every cycle in which `ir_wr` is low.
- R3: The A and B latches load at every edge from the registers named by instruction bits [25:21] and [20:16]. With `src_a_sel`=0, `src_b_sel`=11 and add, the result latch captures PC plus the sign-extended instruction bits [15:0] shifted left by 2.
- R4: The `alu_op` codes are 000 for AND, 001 for OR, 010 for add, 110 for subtract and 111 for signed set-on-less-than, which gives 1 or 0.
- R5: `src_b_sel` selects the second operand: 00 gives B, 01 gives the constant 4, 10 gives the sign-extended immediate and 11 gives the sign-extended immediate shifted left by 2. `src_a_sel` selects the first operand: 0 gives PC and 1 gives A.
- R6: `zero` is high exactly when the current ALU result is all zeros. With `pc_wr_cond`=1 and `pc_sel`=01, the PC loads the result latch only when `zero` is high.
- R7: With `pc_wr`=1 and `pc_sel`=10, the PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R8: When `reg_wr` is high, the destination is IR[15:11] if `reg_dst`=1 and IR[20:16] if `reg_dst`=0. The write data is the memory data register if `mem_to_reg`=1 and the result latch otherwise.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: `mem_addr` is PC when `iord`=0 and the result latch when `iord`=1. `mem_wdata` is the B latch. The memory data register captures `mem_rdata` at every edge.
- R11: Reset clears PC, IR, the memory data register, A, B and the result latch. The PC does not change when neither `pc_wr` nor `pc_wr_cond` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write gated by zero |
| pc_sel | input | 2 | PC source: 00 ALU, 01 result latch, 10 jump target |
| iord | input | 1 | Memory address select: 0 PC, 1 result latch |
| ir_wr | input | 1 | Instruction register load |
| reg_wr | input | 1 | Register file write |
| reg_dst | input | 1 | Destination field: 1 rd, 0 rt |
| mem_to_reg | input | 1 | Write data: 1 memory data, 0 result latch |
| src_a_sel | input | 1 | First operand: 0 PC, 1 A |
| src_b_sel | input | 2 | Second operand select |
| alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (B latch) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU result is zero |

## Verification
Two things can fall in the same cycle. In a fetch step, the instruction register loads from memory at the old PC while the same ALU pass writes PC+4. In a branch step, the compare runs on A and B while the PC may load the target that the previous step placed in the result latch. The bench acts as the sequencer and runs a program that includes a taken branch and a branch that is not taken. It judges each step by reading the PC back through the memory address and by comparing every store against a scoreboard filled from a reference model.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] PCSEL_ALU  = 2'b00;
  localparam logic [1:0] PCSEL_LAT  = 2'b01;
  localparam logic [1:0] PCSEL_JUMP = 2'b10;
endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  import mc_pkg::*;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra0,
  input  logic [$clog2(NREG)-1:0] ra1,
  output logic [W-1:0]            rd0,
  output logic [W-1:0]            rd1
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [1:NREG-1];
  logic         wr_en;

  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[wa] <= wd;
  end

  assign rd0 = (ra0 == '0) ? '0 : regs[ra0];
  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
endmodule

// File: rtl/mc_pc_unit.sv
module mc_pc_unit #(
  parameter int W = 32
) (
  input  logic         wr,
  input  logic         wr_cond,
  input  logic         zero,
  input  logic [1:0]   sel,
  input  logic [W-1:0] alu_y,
  input  logic [W-1:0] alu_lat,
  input  logic [W-1:0] jump_tgt,
  output logic         en,
  output logic [W-1:0] nxt
);
  import mc_pkg::*;

  assign en = wr || (wr_cond && zero);

  always_comb begin
    unique case (sel)
      PCSEL_ALU:  nxt = alu_y;
      PCSEL_LAT:  nxt = alu_lat;
      PCSEL_JUMP: nxt = jump_tgt;
      default:    nxt = alu_y;
    endcase
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pc_wr,
  input  logic         pc_wr_cond,
  input  logic [1:0]   pc_sel,
  input  logic         iord,
  input  logic         ir_wr,
  input  logic         reg_wr,
  input  logic         reg_dst,
  input  logic         mem_to_reg,
  input  logic         src_a_sel,
  input  logic [1:0]   src_b_sel,
  input  logic [2:0]   alu_op,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [5:0]   opcode,
  output logic [5:0]   funct,
  output logic         zero
);
  import mc_pkg::*;

  localparam int AW = $clog2(NREG);
  localparam int IMMW = 16;

  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, lat_q;
  logic [W-1:0] pc_d, rd0, rd1, wdata, opa, opb, alu_y, imm_sx, imm_sh, jump_tgt;
  logic [AW-1:0] ra0, ra1, wa;
  logic pc_en;

  // field extraction and operand steering
  assign ra0      = ir_q[21 +: AW];
  assign ra1      = ir_q[16 +: AW];
  assign wa       = reg_dst ? ir_q[11 +: AW] : ir_q[16 +: AW];
  assign wdata    = mem_to_reg ? mdr_q : lat_q;
  assign imm_sx   = {{(W-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign imm_sh   = {imm_sx[W-3:0], 2'b00};
  assign jump_tgt = {pc_q[W-1:W-4], ir_q[25:0], 2'b00};

  assign opa = src_a_sel ? a_q : pc_q;

  always_comb begin
    unique case (src_b_sel)
      SRCB_REG:   opb = b_q;
      SRCB_FOUR:  opb = W'(4);
      SRCB_IMM:   opb = imm_sx;
      SRCB_IMMSH: opb = imm_sh;
      default:    opb = b_q;
    endcase
  end

  mc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .we(reg_wr), .wa(wa), .wd(wdata),
    .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
  );

  mc_alu #(.W(W)) u_alu (
    .op(alu_op), .a(opa), .b(opb), .y(alu_y), .zero(zero)
  );

  mc_pc_unit #(.W(W)) u_pcu (
    .wr(pc_wr), .wr_cond(pc_wr_cond), .zero(zero), .sel(pc_sel),
    .alu_y(alu_y), .alu_lat(lat_q), .jump_tgt(jump_tgt),
    .en(pc_en), .nxt(pc_d)
  );

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      lat_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (ir_wr) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rd0;
      b_q   <= rd1;
      lat_q <= alu_y;
    end
  end

  assign mem_addr  = iord ? lat_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_sel == PCSEL_ALU && !src_a_sel && src_b_sel == SRCB_FOUR && alu_op == ALU_ADD)
    |=> (pc_q == $past(pc_q) + W'(4))); // R1
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q)); // R2
  AST_COND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && !zero) |=> $stable(pc_q)); // R6
  AST_JUMP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_sel == PCSEL_JUMP)
    |=> (pc_q[1:0] == 2'b00 && pc_q[W-1:W-4] == $past(pc_q[W-1:W-4]))); // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc_q)); // R11
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
  import mc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_wr, pc_wr_cond, iord, ir_wr, reg_wr, reg_dst, mem_to_reg, src_a_sel, mem_we;
  logic [1:0] pc_sel, src_b_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0] opcode, funct;
  logic zero;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rm [0:31];
  logic [31:0] exp_pc;
  logic [31:0] sb_addr[$];
  logic [31:0] sb_data[$];
  string       sb_tag[$];

  always #4 clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_sel(pc_sel),
    .iord(iord), .ir_wr(ir_wr), .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .alu_op(alu_op), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct), .zero(zero)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each memory write
  always begin
    @(negedge clk);
    #2;
    if (mem_we) begin
      if (sb_addr.size() == 0) chk(1'b0, "R10 unexpected store", mem_addr, 32'h0);
      else begin
        logic [31:0] ea, ed;
        string t;
        ea = sb_addr.pop_front();
        ed = sb_data.pop_front();
        t  = sb_tag.pop_front();
        chk(mem_addr == ea, {t, " store addr"}, mem_addr, ea);
        chk(mem_wdata == ed, {t, " store data"}, mem_wdata, ed);
      end
    end
  end

  task automatic clr();
    pc_wr = 0; pc_wr_cond = 0; pc_sel = 0; iord = 0; ir_wr = 0; reg_wr = 0;
    reg_dst = 0; mem_to_reg = 0; src_a_sel = 0; src_b_sel = 0; alu_op = ALU_AND; mem_we = 0;
  endtask

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [2:0] fmap(input logic [5:0] fn);
    case (fn)
      6'd32: return ALU_ADD;
      6'd34: return ALU_SUB;
      6'd36: return ALU_AND;
      6'd37: return ALU_OR;
      default: return ALU_SLT;
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] x, input logic [31:0] y);
    case (fn)
      6'd32: return x + y;
      6'd34: return x - y;
      6'd36: return x & y;
      6'd37: return x | y;
      default: return {31'd0, $signed(x) < $signed(y)};
    endcase
  endfunction

  // bench acts as sequencer; one call per instruction
  task automatic run_instr(input logic [31:0] ins);
    logic [31:0] sx, pc4, ea;
    int rs, rt, rd;
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    pc4 = exp_pc + 32'd4;
    ea = rm[rs] + sx;
    clr(); ir_wr = 1; pc_wr = 1; src_b_sel = SRCB_FOUR; alu_op = ALU_ADD;    // fetch
    @(negedge clk);
    clr(); src_b_sel = SRCB_IMMSH; alu_op = ALU_ADD;                          // decode
    @(negedge clk);
    chk(opcode == ins[31:26], "R1 opcode from IR", {26'd0, opcode}, {26'd0, ins[31:26]});
    case (ins[31:26])
      6'd35: begin
        clr(); src_a_sel = 1; src_b_sel = SRCB_IMM; alu_op = ALU_ADD;
        @(negedge clk);
        clr(); src_a_sel = 1; src_b_sel = SRCB_IMM; alu_op = ALU_ADD; iord = 1;
        #1 chk(mem_addr == ea, "R10 load address", mem_addr, ea);
        @(negedge clk);
        clr(); reg_wr = 1; mem_to_reg = 1;
        @(negedge clk);
        if (rt != 0) rm[rt] = mem[ea[9:2]];
        exp_pc = pc4;
      end
      6'd43: begin
        clr(); src_a_sel = 1; src_b_sel = SRCB_IMM; alu_op = ALU_ADD;
        @(negedge clk);
        sb_addr.push_back(ea); sb_data.push_back(rm[rt]);
        sb_tag.push_back((rt == 0) ? "R9" : "R8");
        clr(); src_a_sel = 1; src_b_sel = SRCB_IMM; alu_op = ALU_ADD; iord = 1; mem_we = 1;
        @(negedge clk);
        exp_pc = pc4;
      end
      6'd0: begin
        clr(); src_a_sel = 1; src_b_sel = SRCB_REG; alu_op = fmap(ins[5:0]);
        @(negedge clk);
        clr(); src_a_sel = 1; alu_op = fmap(ins[5:0]); reg_wr = 1; reg_dst = 1;
        @(negedge clk);
        if (rd != 0) rm[rd] = ref_alu(ins[5:0], rm[rs], rm[rt]);
        exp_pc = pc4;
      end
      6'd4: begin
        clr(); src_a_sel = 1; src_b_sel = SRCB_REG; alu_op = ALU_SUB;
        pc_wr_cond = 1; pc_sel = PCSEL_LAT; iord = 1;
        #1;
        chk(mem_addr == pc4 + (sx << 2), "R3 speculative target", mem_addr, pc4 + (sx << 2));
        chk(zero == (rm[rs] == rm[rt]), "R6 zero flag", {31'd0, zero}, {31'd0, rm[rs] == rm[rt]});
        @(negedge clk);
        exp_pc = (rm[rs] == rm[rt]) ? pc4 + (sx << 2) : pc4;
      end
      default: begin
        clr(); pc_wr = 1; pc_sel = PCSEL_JUMP;
        @(negedge clk);
        exp_pc = {pc4[31:28], ins[25:0], 2'b00};
      end
    endcase
    clr();
    #1 chk(mem_addr == exp_pc, "R11 PC after instruction (R1 R6 R7)", mem_addr, exp_pc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) rm[i] = 32'h0;
    mem[0]  = itype(6'd35, 0, 1, 16'h0100);
    mem[1]  = itype(6'd35, 0, 2, 16'h0104);
    mem[2]  = rtype(1, 2, 3, 6'd32);
    mem[3]  = rtype(1, 2, 4, 6'd34);
    mem[4]  = rtype(1, 2, 5, 6'd36);
    mem[5]  = rtype(1, 2, 6, 6'd37);
    mem[6]  = rtype(2, 1, 7, 6'd42);
    mem[7]  = rtype(1, 2, 8, 6'd42);
    mem[8]  = rtype(1, 1, 0, 6'd32);
    for (int k = 0; k < 7; k++) mem[9 + k] = itype(6'd43, 0, (k == 6) ? 0 : 3 + k, 16'(16'h0108 + 4 * k));
    mem[16] = itype(6'd4, 1, 2, 16'd5);
    mem[17] = itype(6'd4, 3, 3, 16'd2);
    mem[20] = {6'd2, 26'd24};
    mem[24] = itype(6'd35, 0, 9, 16'h0124);
    mem[25] = itype(6'd43, 9, 2, 16'hFFF8);
    mem[64] = 32'h0000_0007;
    mem[65] = 32'hFFFF_FFFB;
    mem[73] = 32'h0000_0130;
    exp_pc = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 32'h0, "R11 reset PC", mem_addr, 32'h0);
    chk(mem_wdata == 32'h0, "R11 reset B", mem_wdata, 32'h0);
    iord = 1;
    #1 chk(mem_addr == 32'h0, "R11 reset result latch", mem_addr, 32'h0);
    src_a_sel = 1; src_b_sel = SRCB_REG; alu_op = ALU_ADD;
    #1 chk(zero == 1'b1, "R6 zero after reset", {31'd0, zero}, 32'h1);
    clr();
    @(negedge clk);
    // R4 R5 R8 R9 R2 checked via stores; R3 R6 R7 via PC and branch checks
    for (int k = 0; k < 21; k++) run_instr(mem[exp_pc[9:2]]);
    repeat (2) @(negedge clk);
    chk(sb_addr.size() == 0, "R10 all stores seen", 32'(sb_addr.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule